// File: doc/BRIEF.md
# Upper-Address Wishbone Slave Router

This block sits between one upstream Wishbone master and a group of 2^SBITS downstream slaves. It takes each transfer from the upstream channel and presents it to all slaves through one set of shared outputs. Only the slave whose index matches the most significant SBITS address bits receives a strobe. Each slave owns an equal window of the address space, and the router clears the index bits on the shared address so that every slave decodes its own window starting at zero.

The forward path (strobe, cycle, lock, write enable, address, write data, byte selects) passes through a single register stage. The response path is not registered. Read data, ack, err, rty and stall come back through a multiplexer that is steered by a slave index captured together with the strobe, so a response is always routed from the slave that was actually strobed. The stall of the strobed slave reaches the upstream port combinationally. While that stall is high, the forward register holds its contents, and a transfer can be accepted on every cycle in which no slave stalls.

Top module: `wbr_router`

## Requirements
- R1: The block serves NSLV = 2^SBITS slaves. Every per-slave response input is a flat vector with one bit per slave, and slave n's read data lies at bits [(n+1)*DW-1 : n*DW] of `dn_dat_i`.
- R2: When a transfer is accepted upstream, the slave index is taken from bits [AW-1 : AW-SBITS] of `up_adr_i`. One cycle later, bit `index` of `dn_stb_o` is high.
- R3: `dn_stb_o` never has more than one bit set. Every slave other than the addressed one sees its strobe low.
- R4: `dn_cyc_o`, `dn_lock_o`, `dn_we_o`, `dn_dat_o` and `dn_sel_o` are single outputs shared by all slaves. Each carries the upstream value from one register stage earlier, and `dn_cyc_o` is high whenever any strobe is high.
- R5: `dn_adr_o` carries the lower AW-SBITS bits of the accepted address unchanged. Its upper SBITS bits are driven to 0.
- R6: `up_ack_o`, `up_err_o`, `up_rty_o` and `up_dat_o` come only from the selected slave. A response asserted by any other slave has no effect on the upstream port.
- R7: `up_stall_o` is high exactly when a strobe is pending downstream and the strobed slave drives its stall high. It follows that slave's stall in the same cycle. While it is high, the downstream strobe, address and data hold steady.
- R8: With no stall, back-to-back upstream transfers complete downstream on consecutive cycles, one per cycle and in issue order.
- R9: The response select changes only when a new strobe is captured. A response that arrives after the strobe has dropped is still routed from the last strobed slave.
- R10: While `rst_n` is low, all strobe bits, `dn_cyc_o` and `dn_lock_o` are 0, and the response select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_cyc_i | input | 1 | Upstream bus cycle |
| up_stb_i | input | 1 | Upstream strobe |
| up_lock_i | input | 1 | Upstream lock |
| up_we_i | input | 1 | Upstream write enable |
| up_adr_i | input | AW | Upstream address; the top SBITS bits pick the slave |
| up_dat_i | input | DW | Upstream write data |
| up_sel_i | input | SELW | Upstream byte selects |
| up_dat_o | output | DW | Read data from the selected slave |
| up_ack_o | output | 1 | Ack from the selected slave |
| up_err_o | output | 1 | Error from the selected slave |
| up_rty_o | output | 1 | Retry from the selected slave |
| up_stall_o | output | 1 | Stall from the strobed slave, combinational |
| dn_cyc_o | output | 1 | Shared cycle to all slaves |
| dn_lock_o | output | 1 | Shared lock to all slaves |
| dn_stb_o | output | NSLV | One-hot per-slave strobes |
| dn_adr_o | output | AW | Shared address with the index bits cleared |
| dn_we_o | output | 1 | Shared write enable |
| dn_dat_o | output | DW | Shared write data |
| dn_sel_o | output | SELW | Shared byte selects |
| dn_dat_i | input | NSLV*DW | Packed read data of all slaves |
| dn_ack_i | input | NSLV | Per-slave ack |
| dn_err_i | input | NSLV | Per-slave error |
| dn_rty_i | input | NSLV | Per-slave retry |
| dn_stall_i | input | NSLV | Per-slave stall |

## Verification
The bench raises responses on slaves that were not strobed. A router that ORs responses together, instead of multiplexing them, would pass these responses upstream as false acks or errors. It then drives a response after the strobe has dropped, which exposes a select that follows the current address rather than the captured one. It also holds a slave's stall across several cycles. A design with a registered stall would release one cycle late, and a forward stage that kept loading would lose or overwrite the stalled strobe. Back-to-back transfers to different slaves, in a shuffled order, catch index decoding from the wrong address bits, upper address bits that are not cleared, and any bubble in the pipeline.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

  // Per-transfer control bits shared by every downstream slave.
  typedef struct packed {
    logic cyc;
    logic lock;
    logic we;
  } wbr_ctl_t;

  localparam wbr_ctl_t WBR_CTL_IDLE = '{cyc: 1'b0, lock: 1'b0, we: 1'b0};

endpackage

// File: rtl/wbr_index_decode.sv
module wbr_index_decode #(
  parameter int SBITS = 2
) (
  input  logic [SBITS-1:0]      idx_i,
  input  logic                  en_i,
  output logic [(1<<SBITS)-1:0] hot_o
);
  localparam int NSLV = 1 << SBITS;

  for (genvar k = 0; k < NSLV; k++) begin : g_hot
    assign hot_o[k] = en_i && (idx_i == SBITS'(k));
  end

endmodule

// File: rtl/wbr_resp_mux.sv
module wbr_resp_mux #(
  parameter int DW    = 32,
  parameter int SBITS = 2
) (
  input  logic [SBITS-1:0]           idx_i,
  input  logic [(1<<SBITS)*DW-1:0]   dat_i,
  input  logic [(1<<SBITS)-1:0]      ack_i,
  input  logic [(1<<SBITS)-1:0]      err_i,
  input  logic [(1<<SBITS)-1:0]      rty_i,
  input  logic [(1<<SBITS)-1:0]      stall_i,
  output logic [DW-1:0]              dat_o,
  output logic                       ack_o,
  output logic                       err_o,
  output logic                       rty_o,
  output logic                       stall_o
);
  localparam int NSLV = 1 << SBITS;

  logic [DW-1:0] slice [NSLV];

  for (genvar k = 0; k < NSLV; k++) begin : g_slice
    assign slice[k] = dat_i[k*DW +: DW];
  end

  always_comb begin
    dat_o   = slice[idx_i];
    ack_o   = ack_i[idx_i];
    err_o   = err_i[idx_i];
    rty_o   = rty_i[idx_i];
    stall_o = stall_i[idx_i];
  end

endmodule

// File: rtl/wbr_fwd_stage.sv
module wbr_fwd_stage
  import wbr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SELW  = 4,
  parameter int SBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  wbr_ctl_t         ctl_i,
  input  logic             stb_i,
  input  logic [AW-1:0]    adr_i,
  input  logic [DW-1:0]    dat_i,
  input  logic [SELW-1:0]  sel_i,
  output wbr_ctl_t         ctl_q,
  output logic             stb_q,
  output logic [AW-1:0]    adr_q,
  output logic [DW-1:0]    dat_q,
  output logic [SELW-1:0]  sel_q,
  output logic [SBITS-1:0] idx_q
);
  localparam int LOW_W = AW - SBITS;

  wbr_ctl_t         ctl_n;
  logic             stb_n;
  logic [AW-1:0]    adr_n;
  logic [DW-1:0]    dat_n;
  logic [SELW-1:0]  sel_n;
  logic [SBITS-1:0] idx_n;

  // Next state: load everything on enable, keep the slave index unless a strobe is taken.
  always_comb begin
    ctl_n = ctl_q;
    stb_n = stb_q;
    adr_n = adr_q;
    dat_n = dat_q;
    sel_n = sel_q;
    idx_n = idx_q;
    if (load_i) begin
      ctl_n = ctl_i;
      stb_n = stb_i;
      adr_n = {{SBITS{1'b0}}, adr_i[LOW_W-1:0]};
      dat_n = dat_i;
      sel_n = sel_i;
      if (stb_i) idx_n = adr_i[AW-1 -: SBITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= WBR_CTL_IDLE;
      stb_q <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
      sel_q <= '0;
      idx_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      stb_q <= stb_n;
      adr_q <= adr_n;
      dat_q <= dat_n;
      sel_q <= sel_n;
      idx_q <= idx_n;
    end
  end

  // R7: a stage that is not loaded keeps the pending strobe and address
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(stb_q) && $stable(adr_q) && $stable(dat_q)));

  // R9: the captured slave index moves only when a strobe is loaded
  p_index_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && stb_i) |=> $stable(idx_q));

endmodule

// File: rtl/wbr_router.sv
module wbr_router
  import wbr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SELW  = DW / 8,
  parameter int SBITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     up_cyc_i,
  input  logic                     up_stb_i,
  input  logic                     up_lock_i,
  input  logic                     up_we_i,
  input  logic [AW-1:0]            up_adr_i,
  input  logic [DW-1:0]            up_dat_i,
  input  logic [SELW-1:0]          up_sel_i,
  output logic [DW-1:0]            up_dat_o,
  output logic                     up_ack_o,
  output logic                     up_err_o,
  output logic                     up_rty_o,
  output logic                     up_stall_o,
  output logic                     dn_cyc_o,
  output logic                     dn_lock_o,
  output logic [(1<<SBITS)-1:0]    dn_stb_o,
  output logic [AW-1:0]            dn_adr_o,
  output logic                     dn_we_o,
  output logic [DW-1:0]            dn_dat_o,
  output logic [SELW-1:0]          dn_sel_o,
  input  logic [(1<<SBITS)*DW-1:0] dn_dat_i,
  input  logic [(1<<SBITS)-1:0]    dn_ack_i,
  input  logic [(1<<SBITS)-1:0]    dn_err_i,
  input  logic [(1<<SBITS)-1:0]    dn_rty_i,
  input  logic [(1<<SBITS)-1:0]    dn_stall_i
);
  localparam int NSLV = 1 << SBITS;

  wbr_ctl_t         ctl_in;
  wbr_ctl_t         ctl_q;
  logic             stb_q;
  logic [SBITS-1:0] idx_q;
  logic             sel_stall;
  logic             load_en;

  assign ctl_in = '{cyc: up_cyc_i, lock: up_lock_i, we: up_we_i};

  // Upstream stall is the strobed slave's stall, with no register in between.
  assign up_stall_o = stb_q && sel_stall;
  assign load_en    = !up_stall_o;

  wbr_fwd_stage #(
    .AW(AW), .DW(DW), .SELW(SELW), .SBITS(SBITS)
  ) u_fwd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_en),
    .ctl_i  (ctl_in),
    .stb_i  (up_stb_i),
    .adr_i  (up_adr_i),
    .dat_i  (up_dat_i),
    .sel_i  (up_sel_i),
    .ctl_q  (ctl_q),
    .stb_q  (stb_q),
    .adr_q  (dn_adr_o),
    .dat_q  (dn_dat_o),
    .sel_q  (dn_sel_o),
    .idx_q  (idx_q)
  );

  wbr_index_decode #(.SBITS(SBITS)) u_dec (
    .idx_i (idx_q),
    .en_i  (stb_q),
    .hot_o (dn_stb_o)
  );

  wbr_resp_mux #(.DW(DW), .SBITS(SBITS)) u_mux (
    .idx_i   (idx_q),
    .dat_i   (dn_dat_i),
    .ack_i   (dn_ack_i),
    .err_i   (dn_err_i),
    .rty_i   (dn_rty_i),
    .stall_i (dn_stall_i),
    .dat_o   (up_dat_o),
    .ack_o   (up_ack_o),
    .err_o   (up_err_o),
    .rty_o   (up_rty_o),
    .stall_o (sel_stall)
  );

  assign dn_cyc_o  = ctl_q.cyc;
  assign dn_lock_o = ctl_q.lock;
  assign dn_we_o   = ctl_q.we;

  // R3: at most one slave strobed
  p_onehot_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_stb_o));

  // R2: a raised strobe sits on the bit of the slave chosen by the captured index
  p_stb_at_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_stb_o) |-> dn_stb_o[idx_q]);

  // R4: no strobe outside a bus cycle
  p_cyc_covers_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_stb_o) |-> dn_cyc_o);

  // R5: the slave index bits never reach the shared address
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_adr_o[AW-1 -: SBITS] == '0);

  // R7: upstream stall only while a strobe is pending
  p_stall_needs_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_stall_o |-> (|dn_stb_o));

endmodule

// File: tb/wbr_router_bench.sv
module wbr_router_bench;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int SELW  = 4;
  localparam int SBITS = 2;
  localparam int NSLV  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic up_cyc_i = 0, up_stb_i = 0, up_lock_i = 0, up_we_i = 0;
  logic [AW-1:0]   up_adr_i = '0;
  logic [DW-1:0]   up_dat_i = '0;
  logic [SELW-1:0] up_sel_i = '0;
  logic [DW-1:0]   up_dat_o;
  logic up_ack_o, up_err_o, up_rty_o, up_stall_o;
  logic dn_cyc_o, dn_lock_o, dn_we_o;
  logic [NSLV-1:0] dn_stb_o;
  logic [AW-1:0]   dn_adr_o;
  logic [DW-1:0]   dn_dat_o;
  logic [SELW-1:0] dn_sel_o;
  logic [NSLV*DW-1:0] dn_dat_i;
  logic [NSLV-1:0] dn_ack_i, dn_err_i, dn_rty_i;
  logic [NSLV-1:0] stall_v = '0, xack = '0, xerr = '0, xrty = '0;

  function automatic logic [DW-1:0] rd_of(int k);
    return 32'hC0DE_0000 + 32'(k * 32'h111);
  endfunction

  // Slave models: fixed read data per slave; ack in the cycle a strobe is taken.
  always_comb begin
    for (int k = 0; k < NSLV; k++) dn_dat_i[k*DW +: DW] = rd_of(k);
  end
  assign dn_ack_i = (dn_stb_o & ~stall_v) | xack;
  assign dn_err_i = xerr;
  assign dn_rty_i = xrty;

  wbr_router u_wbr_router (
    .clk(clk), .rst_n(rst_n),
    .up_cyc_i(up_cyc_i), .up_stb_i(up_stb_i), .up_lock_i(up_lock_i),
    .up_we_i(up_we_i), .up_adr_i(up_adr_i), .up_dat_i(up_dat_i),
    .up_sel_i(up_sel_i), .up_dat_o(up_dat_o), .up_ack_o(up_ack_o),
    .up_err_o(up_err_o), .up_rty_o(up_rty_o), .up_stall_o(up_stall_o),
    .dn_cyc_o(dn_cyc_o), .dn_lock_o(dn_lock_o), .dn_stb_o(dn_stb_o),
    .dn_adr_o(dn_adr_o), .dn_we_o(dn_we_o), .dn_dat_o(dn_dat_o),
    .dn_sel_o(dn_sel_o), .dn_dat_i(dn_dat_i), .dn_ack_i(dn_ack_i),
    .dn_err_i(dn_err_i), .dn_rty_i(dn_rty_i), .dn_stall_i(stall_v)
  );

  typedef struct {
    int              idx;
    logic [AW-1:0]   adr;
    logic [DW-1:0]   dat;
    logic [SELW-1:0] sel;
    logic            we;
    logic            lock;
  } exp_t;

  exp_t exp_q[$];
  int   done_cyc[$];
  int   checks = 0;
  int   failures = 0;
  int   cyc_cnt = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: issue one transfer (called at a falling edge), record it at acceptance.
  task automatic xfer(input int idx, input logic [29:0] low, input logic [DW-1:0] d,
                      input logic we, input logic [SELW-1:0] sel, input logic lock);
    exp_t e;
    up_cyc_i  = 1'b1;
    up_stb_i  = 1'b1;
    up_lock_i = lock;
    up_we_i   = we;
    up_adr_i  = {idx[1:0], low};
    up_dat_i  = d;
    up_sel_i  = sel;
    #1;
    while (up_stall_o) begin
      @(negedge clk);
      #1;
    end
    e.idx = idx; e.adr = {2'b00, low}; e.dat = d; e.sel = sel; e.we = we; e.lock = lock;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic go_idle();
    up_stb_i  = 1'b0;
    up_cyc_i  = 1'b0;
    up_lock_i = 1'b0;
  endtask

  // Monitor: every strobe taken downstream is popped and compared.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && (|(dn_stb_o & ~stall_v))) begin
        done_cyc.push_back(cyc_cnt);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected strobe", 64'(dn_stb_o), 64'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(dn_stb_o == NSLV'(1 << e.idx), "R2 strobe index", 64'(dn_stb_o), 64'(1 << e.idx));
          chk(dn_adr_o == e.adr, "R5 shared address", 64'(dn_adr_o), 64'(e.adr));
          chk(dn_dat_o == e.dat && dn_sel_o == e.sel && dn_we_o == e.we,
              "R4 shared data/sel/we", {dn_dat_o, 27'd0, dn_sel_o, dn_we_o},
              {e.dat, 27'd0, e.sel, e.we});
          chk(dn_cyc_o && dn_lock_o == e.lock, "R4 shared cyc/lock",
              64'({dn_cyc_o, dn_lock_o}), 64'({1'b1, e.lock}));
          chk(up_ack_o && up_dat_o == rd_of(e.idx), "R1 read data from slave slice",
              64'({up_ack_o, up_dat_o}), 64'({1'b1, rd_of(e.idx)}));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n0;
    // R10: reset holds strobes, cycle and lock low even with upstream active
    up_cyc_i = 1'b1; up_stb_i = 1'b1; up_lock_i = 1'b1; up_adr_i = 32'hC000_0010;
    repeat (3) @(negedge clk);
    chk(dn_stb_o == '0 && !dn_cyc_o && !dn_lock_o, "R10 reset outputs",
        64'({dn_stb_o, dn_cyc_o, dn_lock_o}), 64'h0);
    go_idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: select resets to slave 0
    xack = 4'b0001; #1;
    chk(up_ack_o && up_dat_o == rd_of(0), "R10 select is slave 0 after reset",
        64'({up_ack_o, up_dat_o}), 64'({1'b1, rd_of(0)}));
    xack = 4'b0010; #1;
    chk(!up_ack_o, "R10 other slave ignored after reset", 64'(up_ack_o), 64'h0);
    xack = '0;
    @(negedge clk);

    // R2/R5: single transfers to each window, including extreme low addresses
    xfer(3, 30'h3FFF_FFFC, 32'hDEAD_BEEF, 1'b1, 4'hF, 1'b0);
    go_idle(); @(negedge clk);
    xfer(0, 30'h0000_0000, 32'h1234_5678, 1'b0, 4'h3, 1'b1);
    go_idle(); @(negedge clk);

    // R8: back-to-back, shuffled targets, one per cycle
    n0 = done_cyc.size();
    xfer(2, 30'h0000_0100, 32'hAAAA_0001, 1'b1, 4'h1, 1'b0);
    xfer(0, 30'h0000_0104, 32'hAAAA_0002, 1'b0, 4'h2, 1'b0);
    xfer(3, 30'h0000_0108, 32'hAAAA_0003, 1'b1, 4'h4, 1'b1);
    xfer(1, 30'h1555_5555, 32'hAAAA_0004, 1'b0, 4'h8, 1'b1);
    go_idle();
    repeat (2) @(negedge clk);
    chk(done_cyc.size() - n0 == 4, "R8 burst completions", 64'(done_cyc.size() - n0), 64'd4);
    if (done_cyc.size() - n0 == 4)
      chk(done_cyc[n0+3] - done_cyc[n0] == 3, "R8 no bubbles",
          64'(done_cyc[n0+3] - done_cyc[n0]), 64'd3);

    // R9/R6: late responses follow the last strobed slave (1), others ignored
    xack = 4'b0010; #1;
    chk(up_ack_o && up_dat_o == rd_of(1), "R9 late ack routed from last slave",
        64'({up_ack_o, up_dat_o}), 64'({1'b1, rd_of(1)}));
    xack = 4'b1101; #1;
    chk(!up_ack_o, "R6 ack from unselected slaves ignored", 64'(up_ack_o), 64'h0);
    xack = '0; xerr = 4'b0010; xrty = 4'b1101; #1;
    chk(up_err_o && !up_rty_o, "R6 err from selected, rty from others ignored",
        64'({up_err_o, up_rty_o}), 64'b10);
    xerr = 4'b1101; xrty = 4'b0010; #1;
    chk(!up_err_o && up_rty_o, "R6 rty from selected, err from others ignored",
        64'({up_err_o, up_rty_o}), 64'b01);
    xerr = '0; xrty = '0;
    stall_v = 4'b1101; #1;
    chk(!up_stall_o, "R7 no stall without pending strobe", 64'(up_stall_o), 64'h0);
    stall_v = '0;
    @(negedge clk);

    // R7: downstream stall on slave 2 holds the stage and passes through at once
    stall_v = 4'b0100;
    xfer(2, 30'h0000_0ABC, 32'h5555_AAAA, 1'b1, 4'hC, 1'b0);
    go_idle(); #1;
    chk(up_stall_o && dn_stb_o == 4'b0100, "R7 stall seen upstream",
        64'({up_stall_o, dn_stb_o}), 64'({1'b1, 4'b0100}));
    repeat (2) @(negedge clk);
    #1;
    chk(up_stall_o && dn_stb_o == 4'b0100 && dn_adr_o == 32'h0000_0ABC, "R7 stage held while stalled",
        64'({up_stall_o, dn_stb_o, dn_adr_o}), 64'({1'b1, 4'b0100, 32'h0000_0ABC}));
    stall_v = 4'b1011; #1;
    chk(!up_stall_o, "R7 stall released same cycle", 64'(up_stall_o), 64'h0);
    @(negedge clk);
    stall_v = '0; #1;
    chk(dn_stb_o == '0, "R3 strobe dropped after idle load", 64'(dn_stb_o), 64'h0);
    @(negedge clk);

    chk(exp_q.size() == 0, "R8 all issued transfers completed", 64'(exp_q.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule